// File: doc/BRIEF.md
# Peripheral clock gate controller

This block holds one 32-bit gating register. Each bit is the enable request for one peripheral clock gate. Software changes the register through a small write port. The port can load the whole word, or it can set or clear selected bits. The set and clear forms let software switch one gate without a read-modify-write.

The block combines the register with a fixed parent map to produce one effective enable per gate. Most gates are roots fed from a clock domain. Gate 2 is fed from the flash-controller domain, gate 3 from the packet-engine domain, and every other root from the core domain. Four groups of child gates also need their parent gate to be active. This gives a two-level enable tree.

The effective enables are registered, so a parent and its children always change on the same clock edge. A read port returns the raw register word, not the effective enables. The gating cells themselves and the domain clocks sit outside the block; only the domain enables come in as inputs.

Top module: `pclk_gate_ctrl`

## Requirements
- R1: After reset the gating register is all zeros, every `gate_en` bit is 0 and `rd_data` is 0.
- R2: A write with `wr_op` = 2'b00 to offset 0x220 replaces the whole register with `wr_data`.
- R3: A write with `wr_op` = 2'b01 to offset 0x220 sets every register bit that is 1 in `wr_data` and leaves all other bits unchanged.
- R4: A write with `wr_op` = 2'b10 to offset 0x220 clears every register bit that is 1 in `wr_data` and leaves all other bits unchanged.
- R5: A write to any offset other than 0x220, or a write with `wr_op` = 2'b11, leaves the register unchanged.
- R6: `rd_data` shows, one cycle after `rd_addr` is presented, the raw register when `rd_addr` is 0x220 and zero for any other offset. It ignores the domain enables and the parent map. A read in the same cycle as a write returns the value held before that write.
- R7: Root gates are active when their own bit is 1 and their domain enable is 1. The roots are gates 2 (`flash_en`), 3 (`pkt_en`) and all remaining non-child gates, including 14, 16, 17 and 18 (`core_en`).
- R8: Gates 0, 1, 21, 25 and 26 are active only when their own bit is set, `core_en` is 1, and gate 17 is active.
- R9: Gate 4 is active only when bit 4 is set, `core_en` is 1, and gate 18 is active.
- R10: Gates 7, 8, 11, 12 and 13 are active only when their own bit is set, `core_en` is 1, and gate 14 is active.
- R11: Gates 15, 22, 23 and 24 are active only when their own bit is set, `core_en` is 1, and gate 16 is active.
- R12: `gate_en` is registered. It reflects a write, and the domain enables, on the clock edge that ends the cycle in which they were presented. A parent and its children change on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 12 | Write offset |
| wr_op | input | 2 | 00 load, 01 set bits, 10 clear bits, 11 no effect |
| wr_data | input | 32 | Write word or bit mask |
| rd_addr | input | 12 | Read offset |
| rd_data | output | 32 | Registered readback |
| core_en | input | 1 | Core domain enable |
| flash_en | input | 1 | Flash-controller domain enable (gate 2) |
| pkt_en | input | 1 | Packet-engine domain enable (gate 3) |
| gate_en | output | 32 | Registered effective gate enables |

## Verification
A register update and a readback can fall in the same cycle. The bench provokes this by presenting a load and a read of offset 0x220 together. It then expects the old word on `rd_data` while `gate_en` already follows the new word, and it expects the next read to show the new word.

A parent bit and a child bit can also change in the same cycle. The bench judges this by setting a parent and a child in one set-bits write and requiring both enables to rise on the same edge.

// File: rtl/pgc_pkg.sv
package pgc_pkg;

    typedef enum logic [1:0] {
        OP_LOAD = 2'b00,
        OP_SET  = 2'b01,
        OP_CLR  = 2'b10,
        OP_NONE = 2'b11
    } wr_op_e;

    typedef enum logic [1:0] {
        DOM_CORE  = 2'b00,
        DOM_FLASH = 2'b01,
        DOM_PKT   = 2'b10
    } dom_e;

    // Parent gate of each gate, or -1 for a root gate.
    function automatic int parent_of(input int g);
        case (g)
            0, 1, 21, 25, 26:  return 17;
            4:                 return 18;
            7, 8, 11, 12, 13:  return 14;
            15, 22, 23, 24:    return 16;
            default:           return -1;
        endcase
    endfunction

    // Clock domain feeding each gate.
    function automatic dom_e domain_of(input int g);
        case (g)
            2:       return DOM_FLASH;
            3:       return DOM_PKT;
            default: return DOM_CORE;
        endcase
    endfunction

endpackage

// File: rtl/pgc_gate_reg.sv
module pgc_gate_reg #(
    parameter int                N_GATES = 32,
    parameter int                ADDR_W  = 12,
    parameter logic [ADDR_W-1:0] REG_OFS = 12'h220
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [1:0]         wr_op,
    input  logic [N_GATES-1:0] wr_data,
    output logic [N_GATES-1:0] bits_q,
    output logic [N_GATES-1:0] bits_d
);
    import pgc_pkg::*;

    typedef struct packed {
        logic [N_GATES-1:0] bits;
    } reg_state_t;

    reg_state_t st_d, st_q;
    logic       hit;

    always_comb begin
        st_d = st_q;
        hit  = wr_en && (wr_addr == REG_OFS);
        if (hit) begin
            case (wr_op_e'(wr_op))
                OP_LOAD: st_d.bits = wr_data;
                OP_SET:  st_d.bits = st_q.bits | wr_data;
                OP_CLR:  st_d.bits = st_q.bits & ~wr_data;
                default: st_d.bits = st_q.bits;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bits_q = st_q.bits;
    assign bits_d = st_d.bits;

endmodule

// File: rtl/pgc_enable_tree.sv
module pgc_enable_tree #(
    parameter int N_GATES = 32
) (
    input  logic [N_GATES-1:0] bits,
    input  logic               core_en,
    input  logic               flash_en,
    input  logic               pkt_en,
    output logic [N_GATES-1:0] eff
);
    import pgc_pkg::*;

    logic [N_GATES-1:0] dom_ok;

    for (genvar g = 0; g < N_GATES; g++) begin : g_gate
        localparam int   PARENT = parent_of(g);
        localparam dom_e DOM    = domain_of(g);

        if (DOM == DOM_FLASH) begin : g_flash
            assign dom_ok[g] = flash_en;
        end else if (DOM == DOM_PKT) begin : g_pkt
            assign dom_ok[g] = pkt_en;
        end else begin : g_core
            assign dom_ok[g] = core_en;
        end

        if (PARENT >= 0 && PARENT < N_GATES) begin : g_child
            assign eff[g] = bits[g] & dom_ok[g] & bits[PARENT] & dom_ok[PARENT];
        end else begin : g_root
            assign eff[g] = bits[g] & dom_ok[g];
        end
    end

endmodule

// File: rtl/pgc_readback.sv
module pgc_readback #(
    parameter int                N_GATES = 32,
    parameter int                ADDR_W  = 12,
    parameter logic [ADDR_W-1:0] REG_OFS = 12'h220
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  rd_addr,
    input  logic [N_GATES-1:0] bits_q,
    output logic [N_GATES-1:0] rd_data
);
    typedef struct packed {
        logic [N_GATES-1:0] data;
    } rd_state_t;

    rd_state_t rd_d, rd_q;

    always_comb begin
        rd_d.data = (rd_addr == REG_OFS) ? bits_q : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_data = rd_q.data;

endmodule

// File: rtl/pclk_gate_ctrl.sv
module pclk_gate_ctrl #(
    parameter int                N_GATES = 32,
    parameter int                ADDR_W  = 12,
    parameter logic [ADDR_W-1:0] REG_OFS = 12'h220
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [1:0]         wr_op,
    input  logic [N_GATES-1:0] wr_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [N_GATES-1:0] rd_data,
    input  logic               core_en,
    input  logic               flash_en,
    input  logic               pkt_en,
    output logic [N_GATES-1:0] gate_en
);
    typedef struct packed {
        logic [N_GATES-1:0] en;
    } out_state_t;

    logic [N_GATES-1:0] bits_q, bits_d, eff;
    out_state_t         out_d, out_q;

    pgc_gate_reg #(.N_GATES(N_GATES), .ADDR_W(ADDR_W), .REG_OFS(REG_OFS)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_op   (wr_op),
        .wr_data (wr_data),
        .bits_q  (bits_q),
        .bits_d  (bits_d)
    );

    // Tree runs on the next register value so the enables land with the write.
    pgc_enable_tree #(.N_GATES(N_GATES)) u_tree (
        .bits     (bits_d),
        .core_en  (core_en),
        .flash_en (flash_en),
        .pkt_en   (pkt_en),
        .eff      (eff)
    );

    pgc_readback #(.N_GATES(N_GATES), .ADDR_W(ADDR_W), .REG_OFS(REG_OFS)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_addr (rd_addr),
        .bits_q  (bits_q),
        .rd_data (rd_data)
    );

    always_comb begin
        out_d    = out_q;
        out_d.en = eff;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign gate_en = out_q.en;

endmodule

// File: rtl/pclk_gate_ctrl_chk.sv
module pclk_gate_ctrl_chk #(
    parameter int                N_GATES = 32,
    parameter int                ADDR_W  = 12,
    parameter logic [ADDR_W-1:0] REG_OFS = 12'h220
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [ADDR_W-1:0]  wr_addr,
    input logic [1:0]         wr_op,
    input logic [N_GATES-1:0] wr_data,
    input logic [ADDR_W-1:0]  rd_addr,
    input logic [N_GATES-1:0] rd_data,
    input logic               core_en,
    input logic [N_GATES-1:0] gate_en
);
    logic hit;
    assign hit = wr_en && (wr_addr == REG_OFS);

    // R8
    main_child_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_en[0] || gate_en[1] || gate_en[21] || gate_en[25] || gate_en[26]) |-> gate_en[17]);

    // R9
    sdio_child_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gate_en[4] |-> gate_en[18]);

    // R10
    xor_pcie_child_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_en[7] || gate_en[8] || gate_en[11] || gate_en[12] || gate_en[13]) |-> gate_en[14]);

    // R11
    sata_usb_child_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_en[15] || gate_en[22] || gate_en[23] || gate_en[24]) |-> gate_en[16]);

    // R3
    set_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && wr_op == 2'b01 && wr_data[14] && core_en) |=> gate_en[14]);

    // R4
    clr_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && wr_op == 2'b10 && wr_data[17]) |=> (!gate_en[17] && !gate_en[0]));

    // R6
    stray_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr != REG_OFS) |=> (rd_data == '0));

endmodule

bind pclk_gate_ctrl pclk_gate_ctrl_chk #(
    .N_GATES (N_GATES),
    .ADDR_W  (ADDR_W),
    .REG_OFS (REG_OFS)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_op   (wr_op),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .core_en (core_en),
    .gate_en (gate_en)
);

// File: tb/sim_pclk_gate_ctrl.sv
`timescale 1ns/1ps
module sim_pclk_gate_ctrl;

    localparam logic [11:0] OFS = 12'h220;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [1:0]  wr_op = '0;
    logic [31:0] wr_data = '0;
    logic [11:0] rd_addr = '0;
    logic [31:0] rd_data;
    logic        core_en = 1'b0;
    logic        flash_en = 1'b0;
    logic        pkt_en = 1'b0;
    logic [31:0] gate_en;

    int n_vec = 0;
    int n_bad = 0;
    logic [31:0] m_reg = '0;
    logic [31:0] seed = 32'h1234_5678;
    bit done = 0;

    typedef struct {
        logic [31:0] g;
        logic [31:0] rd;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    pclk_gate_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_op(wr_op), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .core_en(core_en), .flash_en(flash_en), .pkt_en(pkt_en), .gate_en(gate_en)
    );

    function automatic logic [31:0] model_eff(logic [31:0] r, logic c, logic f, logic p);
        logic [31:0] e;
        for (int i = 0; i < 32; i++) begin
            logic dom, par;
            dom = (i == 2) ? f : (i == 3) ? p : c;
            par = 1'b1;
            if (i inside {0, 1, 21, 25, 26})      par = r[17] & c;
            else if (i == 4)                      par = r[18] & c;
            else if (i inside {7, 8, 11, 12, 13}) par = r[14] & c;
            else if (i inside {15, 22, 23, 24})   par = r[16] & c;
            e[i] = r[i] & dom & par;
        end
        return e;
    endfunction

    task automatic step(input logic we, input logic [11:0] wa, input logic [1:0] op,
                        input logic [31:0] wd, input logic [11:0] ra,
                        input logic c, input logic f, input logic p, input string tag);
        exp_t e;
        logic [31:0] nxt;
        @(negedge clk);
        wr_en = we; wr_addr = wa; wr_op = op; wr_data = wd;
        rd_addr = ra; core_en = c; flash_en = f; pkt_en = p;
        nxt = m_reg;
        if (we && wa == OFS) begin
            case (op)
                2'b00: nxt = wd;
                2'b01: nxt = m_reg | wd;
                2'b10: nxt = m_reg & ~wd;
                default: nxt = m_reg;
            endcase
        end
        e.rd  = (ra == OFS) ? m_reg : 32'h0;
        e.g   = model_eff(nxt, c, f, p);
        e.tag = tag;
        sb.push_back(e);
        m_reg = nxt;
    endtask

    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_vec++;
            if (gate_en !== e.g || rd_data !== e.rd) begin
                n_bad++;
                $display("FAIL %s: gate_en=%h exp %h, rd_data=%h exp %h",
                         e.tag, gate_en, e.g, rd_data, e.rd);
            end
        end
    end

    initial begin
        #100000;
        if (!done) begin
            n_bad++;
            n_vec++;
            $display("FAIL watchdog: timeout actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        n_vec++;   // R1 reset state
        if (gate_en !== 32'h0 || rd_data !== 32'h0) begin
            n_bad++;
            $display("FAIL R1: gate_en=%h rd_data=%h expected 0 0", gate_en, rd_data);
        end
        rst_n = 1'b1;
        step(0, OFS, 2'b00, 0, OFS, 1, 1, 1, "R1");
        step(1, OFS, 2'b00, 32'hFFFF_FFFF, OFS, 1, 1, 1, "R2");
        step(0, OFS, 2'b00, 0, OFS, 1, 1, 1, "R2");
        step(0, OFS, 2'b00, 0, OFS, 1, 0, 1, "R7");
        step(0, OFS, 2'b00, 0, OFS, 1, 1, 0, "R7");
        step(0, OFS, 2'b00, 0, OFS, 0, 1, 1, "R7");
        step(1, OFS, 2'b10, 32'h0002_0000, OFS, 1, 1, 1, "R4");
        step(0, OFS, 2'b00, 0, OFS, 1, 1, 1, "R8");
        step(1, OFS, 2'b01, 32'h0002_0000, OFS, 1, 1, 1, "R3");
        step(1, OFS, 2'b10, 32'h0004_0000, OFS, 1, 1, 1, "R9");
        step(1, OFS, 2'b10, 32'h0000_4000, OFS, 1, 1, 1, "R10");
        step(1, OFS, 2'b10, 32'h0001_0000, OFS, 1, 1, 1, "R11");
        step(1, OFS, 2'b11, 32'h0000_0000, OFS, 1, 1, 1, "R5");
        step(1, 12'h224, 2'b00, 32'h0000_0000, OFS, 1, 1, 1, "R5");
        step(0, OFS, 2'b00, 0, 12'h224, 1, 1, 1, "R6");
        step(0, OFS, 2'b00, 0, OFS, 0, 0, 0, "R6");
        step(1, OFS, 2'b00, 32'h0000_0001, OFS, 1, 1, 1, "R12");
        step(1, OFS, 2'b01, 32'h0002_0002, OFS, 1, 1, 1, "R12");
        step(0, OFS, 2'b00, 0, OFS, 1, 1, 1, "R8");
        for (int k = 0; k < 60; k++) begin
            logic [11:0] a;
            seed = seed ^ (seed << 13);
            seed = seed ^ (seed >> 17);
            seed = seed ^ (seed << 5);
            a = (seed[3:0] == 4'h0) ? 12'h120 : OFS;
            step(seed[4], a, seed[6:5], {seed[15:0], seed[31:16]},
                 seed[7] ? OFS : 12'h0, seed[8] | seed[9], seed[10], seed[11], "R12");
        end
        step(0, OFS, 2'b00, 0, OFS, 1, 1, 1, "R6");
        repeat (3) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule